// File: doc/BRIEF.md
# Mailbox and Doorbell Interrupt Unit

This block is the register file that lets a local processor and a remote bus master signal each other. Each direction has two 32-bit message registers and one doorbell register. Writing a message register, or writing a nonzero value to a doorbell, records an event in that direction's status register. Four event inputs from the neighbouring queue logic also record events there.

Each status bit has a mask bit beside it. A mask bit of 1 enables its event. The local side owns the inbound registers and gets the `irq_local` output. The remote side owns the outbound registers and gets the `irq_remote` output.

Access is through one register port. Each access is a single cycle with a side flag, and read data is returned combinationally in the same cycle. Reads of doorbell and status registers clear them at the end of that access cycle.

Top module: `mdb_unit`

## Requirements
- R1: After reset every message, doorbell, status and mask register is zero, and both interrupt outputs are low.
- R2: A remote write to offset 0x50 or 0x54 stores inbound message 0 or 1 and sets inbound status bit 0 or 1. A local read of that offset returns the stored value and leaves it unchanged.
- R3: A local write to offset 0x58 or 0x5C stores outbound message 0 or 1 and sets outbound status bit 0 or 1. A remote read of that offset returns the stored value.
- R4: A doorbell write ORs the written bits into the register. The outbound doorbell is at 0x60: the local side writes it and the remote side reads it. The inbound doorbell is at 0x68: the remote side writes it and the local side reads it. A read by the owning side returns the contents and clears the register to zero.
- R5: A doorbell write with any nonzero bit sets doorbell status bit 3 in its direction. A write of zero leaves the status unchanged.
- R6: In an inbound doorbell write, bit 31 is the machine-check flag and sets inbound status bit 4. Bits 30:0, if nonzero, set bit 3. Each status bit is set independently of the other.
- R7: A status read returns status AND mask and clears every status bit, whether or not it is enabled. The outbound status is read by the remote side at 0x30 and uses bits 0, 1, 3 and 5. The inbound status is read by the local side at 0x100 and uses bits 0, 1, 3, 4, 5, 7 and 8. All other bits read as zero.
- R8: The outbound mask is written and read by the remote side at 0x34. The inbound mask is written and read by the local side at 0x104. Each mask keeps only the implemented status bits. `irq_local` is the OR of the inbound status bits that are both set and enabled; `irq_remote` is the same for the outbound direction.
- R9: Queue event pulses set status bits as follows. `ev_out_post_ne` sets outbound bit 5. `ev_in_post` sets inbound bit 5. `ev_in_post_ovf` sets inbound bit 7. `ev_out_free_ovf` sets inbound bit 8.
- R10: When a clearing status read and a queue event occur in the same cycle, the event's bit ends up set.
- R11: A write from the side that does not own a register is ignored. A read from that side, or a read of an unmapped offset, returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_remote | input | 1 | 1 = access from the remote master, 0 = from the local processor |
| acc_addr | input | 12 | Register byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| ev_out_post_ne | input | 1 | Outbound post queue became non-empty (pulse) |
| ev_in_post | input | 1 | Inbound post queue event (pulse) |
| ev_in_post_ovf | input | 1 | Inbound post queue overflow (pulse) |
| ev_out_free_ovf | input | 1 | Outbound free queue overflow (pulse) |
| irq_local | output | 1 | Interrupt toward the local processor |
| irq_remote | output | 1 | Interrupt toward the remote master |

## Verification
Message traffic is tried three ways: with all masks closed, with every bit open, and with a partial mask. These separate the recording of an event from the raising of an interrupt, and show that a masked bit is hidden on read yet still cleared by it.

Doorbell traffic uses several ORed writes, a zero write and a machine-check-only write. These separate accumulation, the nonzero rule and the two independent inbound flags. Queue pulses are applied alone and in the same cycle as a clearing status read, which exposes a clear that wins over a set. Wrong-side writes and reads, and unmapped reads, confirm that ownership is enforced without side effects.

// File: rtl/mdb_pkg.sv
// Shared constants for the mailbox/doorbell unit: register offsets,
// status bit positions and implemented-bit masks.
package mdb_pkg;
    localparam int DW      = 32;
    localparam int ADDR_W  = 12;
    localparam int NUM_MSG = 2;
    localparam int STAT_W  = 9;

    localparam logic [ADDR_W-1:0] OFS_OUT_STAT = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_OUT_MASK = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_IN_MSG   = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_OUT_MSG  = 12'h058;
    localparam logic [ADDR_W-1:0] OFS_OUT_DB   = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_IN_DB    = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_IN_STAT  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_IN_MASK  = 12'h104;

    localparam int B_DB      = 3;
    localparam int B_MCHK    = 4;
    localparam int B_POST    = 5;
    localparam int B_IPOVF   = 7;
    localparam int B_OFOVF   = 8;
    localparam int MCHK_WBIT = DW - 1;

    localparam logic [STAT_W-1:0] OUT_IMPL = 9'h02B;
    localparam logic [STAT_W-1:0] IN_IMPL  = 9'h1BB;
endpackage

// File: rtl/mdb_msg_bank.sv
// Bank of NUM message registers, one write enable per register.
// Assumes at most one enable is active per cycle (single access port).
module mdb_msg_bank #(
    parameter int NUM = 2,
    parameter int W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM-1:0]        wr_en,
    input  logic [W-1:0]          wdata,
    output logic [NUM-1:0][W-1:0] msg
);
    for (genvar i = 0; i < NUM; i++) begin : g_reg
        // Hold message i; load it on its write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        msg[i] <= '0;
            else if (wr_en[i]) msg[i] <= wdata;
        end
    end
endmodule

// File: rtl/mdb_doorbell.sv
// Doorbell register: writes OR bits in, an owner read clears it.
// Assumes a write and a clearing read never share a cycle (single port).
module mdb_doorbell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    output logic [W-1:0] db
);
    // Accumulate written bits; clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)      db <= '0;
        else if (rd_clr) db <= '0;
        else if (wr_en)  db <= db | wdata;
    end
endmodule

// File: rtl/mdb_evt_status.sv
// Event status and enable mask for one direction, plus its interrupt.
// Only bits set in IMPL exist; a set in the same cycle as a clearing read wins.
module mdb_evt_status #(
    parameter int            W    = 9,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         rd_clr,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         irq
);
    // Sticky status bits, cleared by read, set events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (rd_clr ? '0 : stat) | (set & IMPL);
    end

    // Enable mask, keeping implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_wdata & IMPL;
    end

    // Interrupt is any enabled pending event.
    always_comb irq = |(stat & mask);
endmodule

// File: rtl/mdb_unit.sv
// Mailbox and doorbell interrupt unit top: decodes single-cycle accesses
// tagged by side, owns inbound (local-read) and outbound (remote-read)
// registers, and drives one interrupt toward each side.
// Assumes at most one access per cycle; read data is combinational.
module mdb_unit
    import mdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_remote,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    input  logic              ev_out_post_ne,
    input  logic              ev_in_post,
    input  logic              ev_in_post_ovf,
    input  logic              ev_out_free_ovf,
    output logic              irq_local,
    output logic              irq_remote
);
    localparam int PAD = DW - STAT_W;

    logic loc_wr, loc_rd, rem_wr, rem_rd;
    logic [NUM_MSG-1:0]        in_msg_wr, out_msg_wr, in_msg_hit, out_msg_hit;
    logic [NUM_MSG-1:0][DW-1:0] in_msg, out_msg;
    logic [DW-1:0]     in_db, out_db;
    logic [STAT_W-1:0] in_set, out_set, in_stat, out_stat, in_mask, out_mask;
    logic in_db_wr, out_db_wr, in_db_clr, out_db_clr;
    logic in_stat_clr, out_stat_clr, in_mask_wr, out_mask_wr;

    // Split the access by side and direction.
    always_comb begin
        loc_wr = acc_en && !acc_remote && acc_wr;
        loc_rd = acc_en && !acc_remote && !acc_wr;
        rem_wr = acc_en && acc_remote && acc_wr;
        rem_rd = acc_en && acc_remote && !acc_wr;
    end

    // Message offset hits, one per register.
    always_comb begin
        for (int i = 0; i < NUM_MSG; i++) begin
            in_msg_hit[i]  = acc_addr == ADDR_W'(OFS_IN_MSG + 4 * i);
            out_msg_hit[i] = acc_addr == ADDR_W'(OFS_OUT_MSG + 4 * i);
        end
        in_msg_wr  = rem_wr ? in_msg_hit : '0;
        out_msg_wr = loc_wr ? out_msg_hit : '0;
    end

    // Doorbell, status and mask controls; only the owning side acts.
    always_comb begin
        in_db_wr     = rem_wr && acc_addr == OFS_IN_DB;
        out_db_wr    = loc_wr && acc_addr == OFS_OUT_DB;
        in_db_clr    = loc_rd && acc_addr == OFS_IN_DB;
        out_db_clr   = rem_rd && acc_addr == OFS_OUT_DB;
        in_stat_clr  = loc_rd && acc_addr == OFS_IN_STAT;
        out_stat_clr = rem_rd && acc_addr == OFS_OUT_STAT;
        in_mask_wr   = loc_wr && acc_addr == OFS_IN_MASK;
        out_mask_wr  = rem_wr && acc_addr == OFS_OUT_MASK;
    end

    // Collect the set events for each direction.
    always_comb begin
        in_set  = '0;
        out_set = '0;
        in_set[NUM_MSG-1:0]  = in_msg_wr;
        out_set[NUM_MSG-1:0] = out_msg_wr;
        in_set[B_DB]    = in_db_wr && (|acc_wdata[MCHK_WBIT-1:0]);
        in_set[B_MCHK]  = in_db_wr && acc_wdata[MCHK_WBIT];
        in_set[B_POST]  = ev_in_post;
        in_set[B_IPOVF] = ev_in_post_ovf;
        in_set[B_OFOVF] = ev_out_free_ovf;
        out_set[B_DB]   = out_db_wr && (|acc_wdata);
        out_set[B_POST] = ev_out_post_ne;
    end

    mdb_msg_bank #(.NUM(NUM_MSG), .W(DW)) u_in_msg (
        .clk(clk), .rst_n(rst_n), .wr_en(in_msg_wr), .wdata(acc_wdata), .msg(in_msg));
    mdb_msg_bank #(.NUM(NUM_MSG), .W(DW)) u_out_msg (
        .clk(clk), .rst_n(rst_n), .wr_en(out_msg_wr), .wdata(acc_wdata), .msg(out_msg));

    mdb_doorbell #(.W(DW)) u_in_db (
        .clk(clk), .rst_n(rst_n), .wr_en(in_db_wr), .wdata(acc_wdata),
        .rd_clr(in_db_clr), .db(in_db));
    mdb_doorbell #(.W(DW)) u_out_db (
        .clk(clk), .rst_n(rst_n), .wr_en(out_db_wr), .wdata(acc_wdata),
        .rd_clr(out_db_clr), .db(out_db));

    mdb_evt_status #(.W(STAT_W), .IMPL(IN_IMPL)) u_in_stat (
        .clk(clk), .rst_n(rst_n), .set(in_set), .rd_clr(in_stat_clr),
        .mask_wr(in_mask_wr), .mask_wdata(acc_wdata[STAT_W-1:0]),
        .stat(in_stat), .mask(in_mask), .irq(irq_local));
    mdb_evt_status #(.W(STAT_W), .IMPL(OUT_IMPL)) u_out_stat (
        .clk(clk), .rst_n(rst_n), .set(out_set), .rd_clr(out_stat_clr),
        .mask_wr(out_mask_wr), .mask_wdata(acc_wdata[STAT_W-1:0]),
        .stat(out_stat), .mask(out_mask), .irq(irq_remote));

    // Read mux: each side sees only the registers it owns.
    always_comb begin
        acc_rdata = '0;
        if (loc_rd) begin
            for (int i = 0; i < NUM_MSG; i++)
                if (in_msg_hit[i]) acc_rdata = in_msg[i];
            if (acc_addr == OFS_IN_DB)   acc_rdata = in_db;
            if (acc_addr == OFS_IN_STAT) acc_rdata = {{PAD{1'b0}}, in_stat & in_mask};
            if (acc_addr == OFS_IN_MASK) acc_rdata = {{PAD{1'b0}}, in_mask};
        end else if (rem_rd) begin
            for (int i = 0; i < NUM_MSG; i++)
                if (out_msg_hit[i]) acc_rdata = out_msg[i];
            if (acc_addr == OFS_OUT_DB)   acc_rdata = out_db;
            if (acc_addr == OFS_OUT_STAT) acc_rdata = {{PAD{1'b0}}, out_stat & out_mask};
            if (acc_addr == OFS_OUT_MASK) acc_rdata = {{PAD{1'b0}}, out_mask};
        end
    end
endmodule

// File: rtl/mdb_unit_chk.sv
// Checker for mdb_unit: temporal properties on ports and internal state.
// Bound into every mdb_unit instance below.
module mdb_unit_chk
    import mdb_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        acc_en,
    input logic                        acc_wr,
    input logic                        acc_remote,
    input logic [ADDR_W-1:0]           acc_addr,
    input logic                        ev_in_post,
    input logic                        ev_in_post_ovf,
    input logic                        ev_out_free_ovf,
    input logic [STAT_W-1:0]           in_stat,
    input logic [DW-1:0]               out_db,
    input logic [NUM_MSG-1:0][DW-1:0]  in_msg,
    input logic                        irq_local,
    input logic                        irq_remote
);
    // R1: interrupts are quiet in the cycle after a reset cycle.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!irq_local && !irq_remote));

    // R2: remote write of inbound message 0 sets its status bit.
    a_r2_msg_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_remote && acc_addr == OFS_IN_MSG) |=> in_stat[0]);

    // R4: owner read of the outbound doorbell empties it.
    a_r4_db_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_remote && acc_addr == OFS_OUT_DB) |=> out_db == '0);

    // R7: local status read with no concurrent event leaves status empty.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !acc_remote && acc_addr == OFS_IN_STAT &&
         !ev_in_post && !ev_in_post_ovf && !ev_out_free_ovf) |=> in_stat == '0);

    // R10: a queue event always leaves its bit set.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_post |=> in_stat[B_POST]);

    // R11: local write to an inbound message register changes nothing.
    a_r11_wrong_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_remote && acc_addr == OFS_IN_MSG) |=> $stable(in_msg));
endmodule

bind mdb_unit mdb_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_remote(acc_remote), .acc_addr(acc_addr), .ev_in_post(ev_in_post),
    .ev_in_post_ovf(ev_in_post_ovf), .ev_out_free_ovf(ev_out_free_ovf),
    .in_stat(in_stat), .out_db(out_db), .in_msg(in_msg),
    .irq_local(irq_local), .irq_remote(irq_remote));

// File: tb/mdb_unit_bench.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module mdb_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_remote = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        ev_out_post_ne = 1'b0, ev_in_post = 1'b0;
    logic        ev_in_post_ovf = 1'b0, ev_out_free_ovf = 1'b0;
    logic        irq_local, irq_remote;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam bit LOC = 1'b0;
    localparam bit REM = 1'b1;

    always #10 clk = ~clk;

    mdb_unit u_mdb_unit (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_remote(acc_remote), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .ev_out_post_ne(ev_out_post_ne),
        .ev_in_post(ev_in_post), .ev_in_post_ovf(ev_in_post_ovf),
        .ev_out_free_ovf(ev_out_free_ovf), .irq_local(irq_local),
        .irq_remote(irq_remote));

    // Monitor: compare read data mid-cycle against the scoreboard.
    always @(negedge clk) begin
        if (acc_en && !acc_wr && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (acc_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", t, acc_rdata, e);
            end
        end
    end

    task automatic acc(input bit side, input bit wr, input logic [11:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_wr = wr; acc_remote = side; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic wr(input bit side, input logic [11:0] a, input logic [31:0] d);
        acc(side, 1'b1, a, d);
    endtask

    task automatic rd(input bit side, input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        acc(side, 1'b0, a, 32'h0);
    endtask

    task automatic chk_irq(input logic exp_l, input logic exp_r, input string t);
        n_chk++;
        if (irq_local !== exp_l || irq_remote !== exp_r) begin
            n_fail++;
            $display("FAIL %s: irq local/remote=%b%b expected %b%b", t,
                     irq_local, irq_remote, exp_l, exp_r);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_irq(1'b0, 1'b0, "R1");
        rd(LOC, 12'h100, 32'h0, "R1");
        rd(LOC, 12'h050, 32'h0, "R1");
        rd(REM, 12'h034, 32'h0, "R1");

        // R2: inbound messages, masks closed
        wr(REM, 12'h050, 32'hA5A5_0001);
        wr(REM, 12'h054, 32'h1234_5678);
        rd(LOC, 12'h050, 32'hA5A5_0001, "R2");
        rd(LOC, 12'h050, 32'hA5A5_0001, "R2");
        rd(LOC, 12'h054, 32'h1234_5678, "R2");
        chk_irq(1'b0, 1'b0, "R8");
        wr(LOC, 12'h104, 32'h3);
        chk_irq(1'b1, 1'b0, "R8");
        rd(LOC, 12'h100, 32'h3, "R7");
        chk_irq(1'b0, 1'b0, "R7");
        rd(LOC, 12'h100, 32'h0, "R7");

        // R8 partial mask: masked bit hidden yet cleared
        wr(LOC, 12'h104, 32'h1);
        wr(REM, 12'h054, 32'h0000_0042);
        chk_irq(1'b0, 1'b0, "R8");
        wr(REM, 12'h050, 32'hA5A5_0001);
        chk_irq(1'b1, 1'b0, "R8");
        rd(LOC, 12'h100, 32'h1, "R7");
        rd(LOC, 12'h100, 32'h0, "R7");

        // R3: outbound messages
        wr(LOC, 12'h058, 32'hDEAD_BEEF);
        wr(LOC, 12'h05C, 32'h0BAD_F00D);
        rd(REM, 12'h058, 32'hDEAD_BEEF, "R3");
        rd(REM, 12'h05C, 32'h0BAD_F00D, "R3");
        wr(REM, 12'h034, 32'hFFFF_FFFF);
        rd(REM, 12'h034, 32'h0000_002B, "R8");
        chk_irq(1'b0, 1'b1, "R3");
        rd(REM, 12'h030, 32'h3, "R3");
        chk_irq(1'b0, 1'b0, "R7");

        // R4/R5: outbound doorbell
        wr(LOC, 12'h060, 32'h5);
        wr(LOC, 12'h060, 32'h30);
        rd(REM, 12'h030, 32'h8, "R5");
        rd(REM, 12'h060, 32'h35, "R4");
        rd(REM, 12'h060, 32'h0, "R4");
        wr(LOC, 12'h060, 32'h0);
        rd(REM, 12'h030, 32'h0, "R5");

        // R6: inbound doorbell and machine check
        wr(LOC, 12'h104, 32'h1FF);
        rd(LOC, 12'h104, 32'h0000_01BB, "R8");
        wr(REM, 12'h068, 32'h8000_0000);
        rd(LOC, 12'h100, 32'h10, "R6");
        wr(REM, 12'h068, 32'h0000_0100);
        rd(LOC, 12'h100, 32'h08, "R6");
        rd(LOC, 12'h068, 32'h8000_0100, "R4");
        rd(LOC, 12'h068, 32'h0, "R4");

        // R9: queue event inputs
        ev_in_post = 1'b1; idle(); ev_in_post = 1'b0;
        chk_irq(1'b1, 1'b0, "R9");
        rd(LOC, 12'h100, 32'h20, "R9");
        ev_in_post_ovf = 1'b1; ev_out_free_ovf = 1'b1; idle();
        ev_in_post_ovf = 1'b0; ev_out_free_ovf = 1'b0;
        rd(LOC, 12'h100, 32'h180, "R9");
        ev_out_post_ne = 1'b1; idle(); ev_out_post_ne = 1'b0;
        chk_irq(1'b0, 1'b1, "R9");
        rd(REM, 12'h030, 32'h20, "R9");

        // R10: event during clearing read
        ev_in_post = 1'b1;
        rd(LOC, 12'h100, 32'h0, "R10");
        ev_in_post = 1'b0;
        chk_irq(1'b1, 1'b0, "R10");
        rd(LOC, 12'h100, 32'h20, "R10");

        // R11: wrong side and unmapped
        wr(LOC, 12'h050, 32'hFFFF_FFFF);
        rd(LOC, 12'h050, 32'hA5A5_0001, "R11");
        rd(REM, 12'h050, 32'h0, "R11");
        wr(REM, 12'h050, 32'h7);
        rd(REM, 12'h100, 32'h0, "R11");
        rd(LOC, 12'h100, 32'h1, "R11");
        rd(LOC, 12'h07C, 32'h0, "R11");
        wr(REM, 12'h104, 32'h0);
        rd(LOC, 12'h104, 32'h0000_01BB, "R11");
        wr(REM, 12'h060, 32'hF);
        rd(REM, 12'h060, 32'h0, "R11");

        idle();
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d reads unmatched, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule